// File: doc/BRIEF.md
# Four-Channel Waveform Capture Ring with Packed Readout

The block records a four-channel stream of 10-bit converter samples into a circular store that holds 1024 sample times. An internal pacer produces the sample strobe `smp_tick`, one pulse every `DIV_LO` clocks when `rate_sel` is low and every `DIV_HI` clocks when it is high. The defaults are 5 and 6, which give the fast and slow sample rates from a common fabric clock. On every strobe the sample on `adc_data` is written at the write pointer, and the pointer wraps modulo 1024, so the store always holds the latest 1024 sample times.

A trigger freezes the store and starts a readout. The readout runs at one 32-bit word per clock with no gaps. It begins at the oldest entry and ends at the newest. Each sample time gives two words: a word tagged `10` carrying channels 0 and 1, then a word tagged `11` carrying channels 2 and 3. Both words carry the sample's position in the readout, 0 to 1023. The 2048th word is marked with `out_last`, and circular capture then resumes. A clear input abandons any readout and restarts capture from address 0.

The sequencer has three states:
- FILL: capture.
- DRAIN: one read issued per clock.
- TAIL: one idle clock while the final word leaves.

It has five transitions:
- FILL to DRAIN on trigger.
- DRAIN to TAIL after the 2048th read is issued.
- TAIL to FILL unconditionally.
- DRAIN to FILL on clear.
- FILL to FILL on clear.

Top module: `wave_ring_packer`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `smp_tick` are low. After reset the state is FILL with the write pointer at address 0.
- R2: `smp_tick` pulses once every `DIV_LO` (5) clocks when `rate_sel`=0 and every `DIV_HI` (6) clocks when `rate_sel`=1. Clear restarts the count, so the first pulse comes `DIV` clocks after the clear edge.
- R3: In FILL, each `smp_tick` edge stores `adc_data` at the write pointer, and the pointer advances modulo 1024. The channel fields of `adc_data` are: ch0 [9:0], ch1 [19:10], ch2 [29:20], ch3 [39:30].
- R4: A trigger sampled in FILL starts a readout. The first word is valid two clocks after the trigger edge. Exactly 2048 words follow on consecutive clocks, and `out_valid` is low on the clock after the last word.
- R5: Word pair j (j = 0..1023) is read from address (P + j) mod 1024, where P is the write pointer after the trigger edge. Both words of the pair carry j in bits [9:0].
- R6: In each pair, the first word is {2'b10, ch0, ch1, j} and the second is {2'b11, ch2, ch3, j}. Channels sit at [29:20] and [19:10], and the flag sits at [31:30].
- R7: `out_last` is high on the 2048th word of a readout and on no other word.
- R8: No sample is stored from the trigger edge until the TAIL clock has passed. Capture resumes at the frozen pointer.
- R9: A trigger while in DRAIN or TAIL has no effect. The running readout completes unchanged and no new readout follows it.
- R10: Clear returns the sequencer to FILL from any state, resets the write pointer to 0, and drops `out_valid` on the next clock. When clear and trigger coincide, clear wins and no readout starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Abandon readout, restart capture at address 0 |
| trig | input | 1 | Level trigger, acted on only in FILL |
| rate_sel | input | 1 | Sample pacing: 1 = every DIV_HI clocks, 0 = every DIV_LO |
| adc_data | input | 40 | Four 10-bit channel samples |
| smp_tick | output | 1 | Sample strobe; data is stored on the edge where it is high |
| out_valid | output | 1 | Readout word present |
| out_word | output | 32 | Packed readout word |
| out_last | output | 1 | Final word of a readout |

## Verification
The assertions check the following on every cycle:
- the spacing of sample strobes for the selected rate;
- that a `11` word always follows the `10` word with the same index;
- that indices step by one between pairs;
- that the last flag falls only on index 1023 with tag `11`;
- that the word stream is unbroken until the last word or a clear;
- that clear drops the stream on the next clock;
- that no store write happens while a word is being delivered.

Only the bench scenarios can show that each word's channel contents match what was captured, that readout starts at the oldest entry, and that capture really stays frozen across a readout. They do this by comparing every word of back-to-back, partial-fill, cleared and slow-rate events against an arithmetic model of the store.

// File: rtl/wrp_pkg.sv
package wrp_pkg;

    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_TAIL  = 2'd2
    } seq_state_t;

    localparam logic [1:0] TAG_LOW_PAIR  = 2'b10;
    localparam logic [1:0] TAG_HIGH_PAIR = 2'b11;

endpackage

// File: rtl/wrp_pacer.sv
module wrp_pacer #(
    parameter int DIV_LO = 5,
    parameter int DIV_HI = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic rate_sel,
    output logic tick
);
    localparam int MAXD = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
    localparam int CW   = (MAXD > 1) ? $clog2(MAXD) : 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    always_comb begin
        lim  = rate_sel ? CW'(DIV_HI - 1) : CW'(DIV_LO - 1);
        tick = (cnt >= lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/wrp_store.sv
module wrp_store #(
    parameter int AW = 10,
    parameter int DW = 40
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic          re,
    input  logic [AW-1:0] ra,
    output logic [DW-1:0] q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[wa] <= wd;
        end
    end

    always_ff @(posedge clk) begin
        if (re) begin
            q <= mem[ra];
        end
    end

endmodule

// File: rtl/wrp_seq.sv
module wrp_seq
    import wrp_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          trig,
    input  logic          tick,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic [AW-1:0] rd_idx,
    output logic          rd_half,
    output logic          rd_last
);
    localparam int CW = AW + 1;

    seq_state_t    state;
    seq_state_t    nxt;
    logic [AW-1:0] wr_ptr;
    logic [CW-1:0] rd_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FILL;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_FILL: begin
                if (!clear && trig) begin
                    nxt = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (clear) begin
                    nxt = ST_FILL;
                end else if (&rd_cnt) begin
                    nxt = ST_TAIL;
                end
            end
            ST_TAIL: begin
                nxt = ST_FILL;
            end
            default: nxt = ST_FILL;
        endcase
    end

    always_comb begin
        wr_en   = 1'b0;
        rd_en   = 1'b0;
        unique case (state)
            ST_FILL:  wr_en = tick && !clear;
            ST_DRAIN: rd_en = !clear;
            ST_TAIL:  ;
            default:  ;
        endcase
        wr_addr = wr_ptr;
        rd_idx  = rd_cnt[CW-1:1];
        rd_half = rd_cnt[0];
        rd_last = &rd_cnt;
        rd_addr = wr_ptr + rd_cnt[CW-1:1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_cnt <= '0;
        end else if (clear) begin
            wr_ptr <= '0;
            rd_cnt <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (rd_en) begin
                rd_cnt <= rd_cnt + 1'b1;
            end else begin
                rd_cnt <= '0;
            end
        end
    end

endmodule

// File: rtl/wrp_pack.sv
module wrp_pack
    import wrp_pkg::*;
#(
    parameter int AW = 10,
    parameter int SW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_idx,
    input  logic          rd_half,
    input  logic          rd_last,
    input  logic [4*SW-1:0] q,
    output logic          out_valid,
    output logic [31:0]   out_word,
    output logic          out_last
);
    logic          v_q;
    logic          half_q;
    logic          last_q;
    logic [AW-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q    <= 1'b0;
            half_q <= 1'b0;
            last_q <= 1'b0;
            idx_q  <= '0;
        end else begin
            v_q    <= rd_en && !clear;
            half_q <= rd_half;
            last_q <= rd_last && rd_en && !clear;
            idx_q  <= rd_idx;
        end
    end

    always_comb begin
        out_valid = v_q;
        out_last  = v_q && last_q;
        if (half_q) begin
            out_word = {TAG_HIGH_PAIR, q[3*SW-1:2*SW], q[4*SW-1:3*SW], idx_q};
        end else begin
            out_word = {TAG_LOW_PAIR, q[SW-1:0], q[2*SW-1:SW], idx_q};
        end
    end

endmodule

// File: rtl/wave_ring_packer.sv
module wave_ring_packer
    import wrp_pkg::*;
#(
    parameter int SW     = 10,
    parameter int AW     = 10,
    parameter int DIV_LO = 5,
    parameter int DIV_HI = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           trig,
    input  logic           rate_sel,
    input  logic [4*SW-1:0] adc_data,
    output logic           smp_tick,
    output logic           out_valid,
    output logic [31:0]    out_word,
    output logic           out_last
);
    localparam int DW = 4 * SW;

    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [AW-1:0] rd_idx;
    logic          rd_half;
    logic          rd_last;
    logic [DW-1:0] rd_q;

    wrp_pacer #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .rate_sel (rate_sel),
        .tick     (smp_tick)
    );

    wrp_seq #(.AW(AW)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .trig    (trig),
        .tick    (smp_tick),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_idx  (rd_idx),
        .rd_half (rd_half),
        .rd_last (rd_last)
    );

    wrp_store #(.AW(AW), .DW(DW)) u_store (
        .clk (clk),
        .we  (wr_en),
        .wa  (wr_addr),
        .wd  (adc_data),
        .re  (rd_en),
        .ra  (rd_addr),
        .q   (rd_q)
    );

    wrp_pack #(.AW(AW), .SW(SW)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .rd_en     (rd_en),
        .rd_idx    (rd_idx),
        .rd_half   (rd_half),
        .rd_last   (rd_last),
        .q         (rd_q),
        .out_valid (out_valid),
        .out_word  (out_word),
        .out_last  (out_last)
    );

endmodule

// File: rtl/wrp_checker.sv
module wrp_checker #(
    parameter int AW     = 10,
    parameter int DIV_LO = 5,
    parameter int DIV_HI = 6
) (
    input logic        clk,
    input logic        rst_n,
    input logic        clear,
    input logic        rate_sel,
    input logic        smp_tick,
    input logic        out_valid,
    input logic [31:0] out_word,
    input logic        out_last,
    input logic        wr_en
);
    logic [15:0] gap;
    logic        seen;
    logic        moved;
    logic        rs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap   <= 16'd0;
            seen  <= 1'b0;
            moved <= 1'b0;
            rs_q  <= 1'b0;
        end else begin
            rs_q <= rate_sel;
            if (clear) begin
                gap   <= 16'd1;
                seen  <= 1'b0;
                moved <= 1'b0;
            end else if (smp_tick) begin
                gap   <= 16'd1;
                seen  <= 1'b1;
                moved <= 1'b0;
            end else begin
                if (gap != 16'hFFFF) gap <= gap + 16'd1;
                moved <= moved | (rate_sel != rs_q);
            end
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && !smp_tick)); // R1

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_tick && seen && !moved && !clear && rate_sel == rs_q)
        |-> gap == (rate_sel ? 16'(DIV_HI) : 16'(DIV_LO))); // R2

    AST_STREAM_UNBROKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last && !clear) |=> out_valid); // R4

    AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_word[31:30] == 2'b10 && $past(out_valid))
        |-> out_word[AW-1:0] == $past(out_word[AW-1:0]) + 1'b1); // R5

    AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_word[31:30] == 2'b11)
        |-> ($past(out_valid) && $past(out_word[31:30]) == 2'b10
             && $past(out_word[AW-1:0]) == out_word[AW-1:0])); // R6

    AST_LAST_POSITION: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (out_valid && out_word[31:30] == 2'b11
                      && &out_word[AW-1:0])); // R7

    AST_FROZEN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !wr_en); // R8

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !out_valid); // R10

endmodule

bind wave_ring_packer wrp_checker #(
    .AW     (AW),
    .DIV_LO (DIV_LO),
    .DIV_HI (DIV_HI)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .rate_sel  (rate_sel),
    .smp_tick  (smp_tick),
    .out_valid (out_valid),
    .out_word  (out_word),
    .out_last  (out_last),
    .wr_en     (wr_en)
);

// File: tb/wave_ring_packer_test.sv
module wave_ring_packer_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 1024;
    localparam int NWORDS     = 2 * DEPTH;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        clear;
    logic        trig;
    logic        rate_sel;
    logic [39:0] adc_data;
    logic        smp_tick;
    logic        out_valid;
    logic [31:0] out_word;
    logic        out_last;

    int n_chk  = 0;
    int n_fail = 0;
    bit fin    = 1'b0;

    logic [39:0] model [DEPTH];
    int  mwp, ms, wj, age, ncyc, since;
    bit  filling, pend, tseen;

    always #(CLK_PERIOD/2) clk = ~clk;

    wave_ring_packer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .trig      (trig),
        .rate_sel  (rate_sel),
        .adc_data  (adc_data),
        .smp_tick  (smp_tick),
        .out_valid (out_valid),
        .out_word  (out_word),
        .out_last  (out_last)
    );

    function automatic logic [39:0] pat(int k);
        logic [9:0] c0, c1, c2, c3;
        c0 = 10'(k * 3 + 1);
        c1 = 10'(k * 7 + 2);
        c2 = 10'(~k);
        c3 = 10'(k * 13 + 511);
        return {c3, c2, c1, c0};
    endfunction

    function automatic logic [31:0] expw(int j);
        int          pr;
        logic [39:0] d;
        pr = j / 2;
        d  = model[(ms + pr) % DEPTH];
        if (j % 2 == 1) return {2'b11, d[29:20], d[39:30], 10'(pr)};
        else            return {2'b10, d[9:0],   d[19:10], 10'(pr)};
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        if (clear) begin
            mwp = 0; filling = 1'b1; pend = 1'b0; wj = 0; tseen = 1'b0;
        end else begin
            if (filling && smp_tick) begin
                model[mwp] = adc_data;
                mwp = (mwp + 1) % DEPTH;
            end
            if (filling && trig) begin
                filling = 1'b0; ms = mwp; wj = 0; age = 0;
            end
        end
        @(posedge clk);
        @(negedge clk);
        ncyc++;
        age++;
        since++;
        if (pend) begin
            chk(!out_valid, "R4 R9", 32'(out_valid), 32'd0);
            filling = 1'b1;
            pend    = 1'b0;
        end else if (out_valid) begin
            if (wj == 0) chk(age == 2, "R4", 32'(age), 32'd2);
            chk(out_word == expw(wj), "R5 R6", out_word, expw(wj));
            chk(out_last == (wj == NWORDS - 1), "R7", 32'(out_last), 32'(wj == NWORDS - 1));
            if (out_last) begin
                chk(wj == NWORDS - 1, "R4", 32'(wj + 1), 32'(NWORDS));
                pend = 1'b1;
            end
            wj++;
        end
        if (smp_tick) begin
            if (tseen) chk(since == (rate_sel ? 6 : 5), "R2", 32'(since), rate_sel ? 32'd6 : 32'd5);
            tseen = 1'b1;
            since = 0;
        end
        adc_data = pat(ncyc);
    endtask

    task automatic run_ticks(int n);
        int c = 0;
        while (c < n) begin
            if (smp_tick) c++;
            cyc();
        end
    endtask

    task automatic pulse_trig();
        trig = 1'b1; cyc(); trig = 1'b0;
    endtask

    task automatic pulse_clear();
        clear = 1'b1; cyc(); clear = 1'b0;
    endtask

    task automatic drain();
        for (int g = 0; g < 3 * NWORDS && !filling; g++) cyc();
        chk(filling, "R4", 32'(filling), 32'd1);
    endtask

    initial begin
        rst_n = 1'b0; clear = 1'b0; trig = 1'b0; rate_sel = 1'b0;
        adc_data = '0; ncyc = 0; mwp = 0; ms = 0; wj = 0; age = 0;
        since = 0; filling = 1'b1; pend = 1'b0; tseen = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!out_valid && !smp_tick, "R1", {30'd0, out_valid, smp_tick}, 32'd0);
        end
        rst_n = 1'b1;

        // R3: wrap the store, then read a full event oldest first
        run_ticks(1100);
        pulse_trig();
        drain();

        // R8, R9: re-trigger after only three new samples, extra trigger mid-readout
        run_ticks(3);
        pulse_trig();
        while (wj < 500) cyc();
        pulse_trig();
        drain();

        // R10: clear in the middle of a readout
        pulse_trig();
        while (wj < 700) cyc();
        pulse_clear();
        chk(!out_valid, "R10", 32'(out_valid), 32'd0);

        // R2: slow rate, partial fill from address 0
        rate_sel = 1'b1;
        pulse_clear();
        run_ticks(300);
        pulse_trig();
        drain();

        // R10: clear and trigger together
        clear = 1'b1; trig = 1'b1; cyc(); clear = 1'b0; trig = 1'b0;
        for (int i = 0; i < 4; i++) begin
            cyc();
            chk(!out_valid, "R10", 32'(out_valid), 32'd0);
        end
        run_ticks(40);
        pulse_trig();
        drain();

        fin = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!fin) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R4 actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule